// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counters behind a byte-wide register port. Software writes a control byte to pick a channel and how it is to be used, then writes the start count as a low byte followed by a high byte. The loaded channel counts rising edges of its own count-clock input while its gate input is high. Each time it runs out it reloads the start value on its own and pulses its output low for one count-clock period, so the output can serve as a periodic interrupt request.

The host can also freeze a copy of a running count with a latch command and read it back as two bytes without disturbing the counter. All register accesses are synchronous to the system clock. The count clocks are asynchronous inputs: the block synchronises them and acts on their rising edges. Read data appears on `rdata` in the cycle after the read strobe is sampled.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset every channel output is high, `rdata` is 0x00 and no channel counts until it has been programmed.
- R2: A write at address 3 is a control byte: bits 7:6 give the channel (0 to 2), bits 5:4 the access type, bits 3:1 the mode and bit 0 the number format. With access type 11, mode 010 and bit 0 clear, it stops that channel, sets its output high and resets its byte pointers. The channel then keeps its count until it is loaded again.
- R3: Writes at address 0, 1 or 2 load that channel's start value, low byte first and high byte second. The channel stays idle and reads back 0x0000 until the high byte has been written.
- R4: Once loaded with N (2 to 65535), a channel gives one output low pulse per N count-clock rising edges while its gate is high. The output goes low on the edge that brings the count to 1 and goes high on the next edge, which reloads N.
- R5: A start value of 0 counts as 65536: the first edge after loading brings the count to 0xFFFF.
- R6: While a channel's gate is low its count holds and its output is high.
- R7: A control byte with access type 00 latches the addressed channel's current count. The next two reads of that channel return the latched low byte and then the latched high byte, and the second read releases the latch. The counter keeps running while it is latched.
- R8: When no latch is held, two reads of a channel's address return its live count, low byte first.
- R9: A control byte with channel field 11, access type 01 or 10, a mode other than 010, or bit 0 set has no effect, and running channels continue undisturbed.
- R10: A read at address 3 returns 0x00.
- R11: Each channel counts only its own count-clock edges, and loading or reading one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, one access per sampled cycle |
| wr | input | 1 | Write strobe, one access per sampled cycle |
| addr | input | 2 | Register address: 0 to 2 count registers, 3 control |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| cnt_clk | input | 3 | Per-channel count clocks, asynchronous |
| gate | input | 3 | Per-channel count enables |
| tmr_out | output | 3 | Per-channel rate outputs, low pulse at the end of each period |

## Verification
The bench counts count-clock edges one at a time and checks the output on both sides of the edge that brings the count to 1. A design that is off by one in its reload compare would pulse a period early or late, or would hold the output low for two periods. It reads a channel after only its low byte has been written, which catches a design that starts counting too soon. It also reads a latched value after the counter has moved on, which catches a snapshot that follows the live count or is never released. Malformed control bytes are written in the middle of a run, and a later decrement and output pulse show that a design which wrongly decoded them as a reprogram would have stopped the channel. A start value of zero is checked for the wrap to 0xFFFF that a design treating zero as idle would not give.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int NUM_CH = 3;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LOW   = 2'b01,
        ACC_HIGH  = 2'b10,
        ACC_LOHI  = 2'b11
    } access_e;

    localparam logic [2:0] MODE_RATE = 3'b010;
    localparam logic [1:0] CTRL_ADDR = 2'd3;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  snap;
        logic [BYTE_W-1:0] low_hold;
        logic              armed;
        logic              wr_hi;
        logic              rd_hi;
        logic              latched;
        logic              out;
    } ch_state_t;

endpackage

// File: rtl/timer_edge_sync.sv
module timer_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[LEN-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q[LEN-2] & ~sync_q[LEN-1];

endmodule

// File: rtl/timer_bus_decode.sv
module timer_bus_decode
    import timer_pkg::*;
(
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] ctl_load,
    output logic [NUM_CH-1:0] latch_cmd,
    output logic [NUM_CH-1:0] data_wr,
    output logic [NUM_CH-1:0] data_rd
);
    logic       ctl_wr;
    logic [1:0] f_chan;
    access_e    f_acc;
    logic [2:0] f_mode;
    logic       f_bcd;
    logic       load_ok;

    always_comb begin
        ctl_wr  = cs && wr && (addr == CTRL_ADDR);
        f_chan  = wdata[7:6];
        f_acc   = access_e'(wdata[5:4]);
        f_mode  = wdata[3:1];
        f_bcd   = wdata[0];
        load_ok = (f_acc == ACC_LOHI) && (f_mode == MODE_RATE) && !f_bcd;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign ctl_load[i]  = ctl_wr && (f_chan == 2'(i)) && load_ok;
        assign latch_cmd[i] = ctl_wr && (f_chan == 2'(i)) && (f_acc == ACC_LATCH);
        assign data_wr[i]   = cs && wr && (addr == 2'(i));
        assign data_rd[i]   = cs && rd && !wr && (addr == 2'(i));
    end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              gate_i,
    input  logic              ctl_i,
    input  logic              latch_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              out_o
);
    ch_state_t        s_d, s_q;
    logic [CNT_W-1:0] next_cnt;
    logic [CNT_W-1:0] view;

    always_comb begin
        s_d      = s_q;
        next_cnt = (s_q.count == CNT_W'(1)) ? s_q.reload : s_q.count - CNT_W'(1);

        if (tick_i && gate_i && s_q.armed) begin
            s_d.count = next_cnt;
            s_d.out   = (next_cnt != CNT_W'(1));
        end
        if (!gate_i) s_d.out = 1'b1;

        if (latch_i && !s_q.latched) begin
            s_d.snap    = s_q.count;
            s_d.latched = 1'b1;
        end

        if (rd_i) begin
            s_d.rd_hi = !s_q.rd_hi;
            if (s_q.rd_hi && s_q.latched) s_d.latched = 1'b0;
        end

        if (wr_i) begin
            if (!s_q.wr_hi) begin
                s_d.low_hold = wdata_i;
                s_d.wr_hi    = 1'b1;
            end else begin
                s_d.reload = {wdata_i, s_q.low_hold};
                s_d.count  = {wdata_i, s_q.low_hold};
                s_d.armed  = 1'b1;
                s_d.wr_hi  = 1'b0;
                s_d.out    = 1'b1;
            end
        end

        if (ctl_i) begin
            s_d.armed   = 1'b0;
            s_d.wr_hi   = 1'b0;
            s_d.rd_hi   = 1'b0;
            s_d.latched = 1'b0;
            s_d.out     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.out <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        view    = s_q.latched ? s_q.snap : s_q.count;
        rdata_o = s_q.rd_hi ? view[CNT_W-1:BYTE_W] : view[BYTE_W-1:0];
        out_o   = s_q.out;
    end

    // R6: gate low freezes the count
    a_r6_gate_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !wr_i && !ctl_i) |=> $stable(s_q.count));

    // R6: gate low forces the output high
    a_r6_gate_out_high: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |=> s_q.out);

    // R4: an edge at count 1 reloads the start value
    a_r4_reload_at_one: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && tick_i && gate_i && s_q.count == CNT_W'(1) && !wr_i && !ctl_i)
        |=> (s_q.count == s_q.reload));

    // R4: the low pulse lasts until the next count edge
    a_r4_low_until_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.out && !tick_i && gate_i && !wr_i && !ctl_i) |=> !s_q.out);

    // R3: an unloaded channel does not count
    a_r3_idle_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.armed && !wr_i) |=> $stable(s_q.count));

    // R7: a held snapshot stays put until released
    a_r7_snapshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.latched && !ctl_i && !(rd_i && s_q.rd_hi))
        |=> (s_q.latched && $stable(s_q.snap)));

endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [NUM_CH-1:0] cnt_clk,
    input  logic [NUM_CH-1:0] gate,
    output logic [NUM_CH-1:0] tmr_out
);
    logic [NUM_CH-1:0] ctl_load, latch_cmd, data_wr, data_rd, tick;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];
    logic [BYTE_W-1:0] rdata_d, rdata_q;

    timer_bus_decode u_dec (
        .cs        (cs),
        .rd        (rd),
        .wr        (wr),
        .addr      (addr),
        .wdata     (wdata),
        .ctl_load  (ctl_load),
        .latch_cmd (latch_cmd),
        .data_wr   (data_wr),
        .data_rd   (data_rd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        timer_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (cnt_clk[i]),
            .rise_o  (tick[i])
        );

        timer_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick[i]),
            .gate_i  (gate[i]),
            .ctl_i   (ctl_load[i]),
            .latch_i (latch_cmd[i]),
            .wr_i    (data_wr[i]),
            .rd_i    (data_rd[i]),
            .wdata_i (wdata),
            .rdata_o (ch_rdata[i]),
            .out_o   (tmr_out[i])
        );
    end

    always_comb begin
        rdata_d = rdata_q;
        if (cs && rd && !wr) begin
            case (addr)
                2'd0:    rdata_d = ch_rdata[0];
                2'd1:    rdata_d = ch_rdata[1];
                2'd2:    rdata_d = ch_rdata[2];
                default: rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R10: the control address reads as zero
    a_r10_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !wr && addr == CTRL_ADDR) |=> (rdata == '0));

    // R2: a bus cycle reaches at most one channel
    a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctl_load | latch_cmd | data_wr | data_rd));

endmodule

// File: tb/tri_interval_timer_test.sv
`timescale 1ns/1ps
module tri_interval_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] cnt_clk = '0;
    logic [2:0] gate = 3'b111;
    logic [2:0] tmr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    tri_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_clk(cnt_clk), .gate(gate), .tmr_out(tmr_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic read16(input logic [1:0] a, input logic [15:0] e, input string tag);
        bus_read(a, e[7:0], tag);
        bus_read(a, e[15:8], tag);
    endtask

    task automatic pulse(input int ch, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); cnt_clk[ch] = 1'b1;
            repeat (3) @(negedge clk);
            cnt_clk[ch] = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    // monitor: pop and compare one expected byte per sampled read
    initial begin
        forever begin
            @(posedge clk);
            if (cs && rd && !wr) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected read", rdata, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    check(rdata == e, t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tmr_out == 3'b111, "R1 outputs high", tmr_out, 7);
        check(rdata == 8'h00, "R1 rdata zero", rdata, 0);

        // R2/R3: ch0, access 11, mode 010, binary = 0x34
        bus_write(2'd3, 8'h34);
        bus_write(2'd0, 8'h05);
        pulse(0, 2);
        check(tmr_out[0] == 1'b1, "R3 idle after low byte", tmr_out[0], 1);
        read16(2'd0, 16'h0000, "R3 not loaded before high byte");
        bus_write(2'd0, 8'h00);
        read16(2'd0, 16'h0005, "R8 live count after load");
        pulse(0, 1);
        read16(2'd0, 16'h0004, "R8 live count after one edge");
        pulse(0, 2);
        check(tmr_out[0] == 1'b1, "R4 high at count 2", tmr_out[0], 1);
        pulse(0, 1);
        check(tmr_out[0] == 1'b0, "R4 low at count 1", tmr_out[0], 0);
        pulse(0, 1);
        check(tmr_out[0] == 1'b1, "R4 high after reload", tmr_out[0], 1);
        read16(2'd0, 16'h0005, "R4 reloaded value");
        pulse(0, 3);
        check(tmr_out[0] == 1'b1, "R4 high before period end", tmr_out[0], 1);
        pulse(0, 1);
        check(tmr_out[0] == 1'b0, "R4 low at period end", tmr_out[0], 0);
        pulse(0, 1);
        check(tmr_out[0] == 1'b1, "R4 one period low only", tmr_out[0], 1);

        // R6 gate
        gate[0] = 1'b0;
        pulse(0, 2);
        read16(2'd0, 16'h0005, "R6 count held with gate low");
        check(tmr_out[0] == 1'b1, "R6 output high with gate low", tmr_out[0], 1);
        gate[0] = 1'b1;
        pulse(0, 1);
        read16(2'd0, 16'h0004, "R6 resumes with gate high");

        // R7 latch
        bus_write(2'd3, 8'h00);
        pulse(0, 2);
        read16(2'd0, 16'h0004, "R7 latched snapshot");
        read16(2'd0, 16'h0002, "R7 latch released, live count");

        // R9 ignored control bytes
        bus_write(2'd3, 8'hF4);
        bus_write(2'd3, 8'h36);
        bus_write(2'd3, 8'h35);
        bus_write(2'd3, 8'h14);
        pulse(0, 1);
        check(tmr_out[0] == 1'b0, "R9 channel still running", tmr_out[0], 0);
        read16(2'd0, 16'h0001, "R9 count undisturbed");
        pulse(0, 1);

        // R10 control address read
        bus_read(2'd3, 8'h00, "R10 control read zero");

        // R11 independence: ch1 control 0x74
        bus_write(2'd3, 8'h74);
        bus_write(2'd1, 8'h34);
        bus_write(2'd1, 8'h12);
        pulse(1, 3);
        read16(2'd1, 16'h1231, "R11 ch1 counts its own edges");
        read16(2'd0, 16'h0005, "R11 ch0 unchanged");
        check(tmr_out[2] == 1'b1, "R11 ch2 idle high", tmr_out[2], 1);

        // R5 zero means 65536: ch2 control 0xB4
        bus_write(2'd3, 8'hB4);
        bus_write(2'd2, 8'h00);
        bus_write(2'd2, 8'h00);
        read16(2'd2, 16'h0000, "R5 loaded zero");
        pulse(2, 1);
        read16(2'd2, 16'hFFFF, "R5 wraps to FFFF");
        check(tmr_out[2] == 1'b1, "R5 output high", tmr_out[2], 1);

        // R2 reprogramming stops the channel
        bus_write(2'd3, 8'h74);
        pulse(1, 2);
        read16(2'd1, 16'h1231, "R2 control write stops channel");
        check(tmr_out[1] == 1'b1, "R2 output high after control", tmr_out[1], 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule